// File: doc/BRIEF.md
# Two-Channel PWM Output Action Stage with Shadowed Override

This block is the output stage of a two-channel pulse-width generator. A separate time base supplies single-cycle strobes for four events: the counter at zero, the counter at its period value, an up-count match against compare value A, and an up-count match against compare value B. A prescaled tick enable marks the clock cycles in which the time base advances. On every tick, each output looks up the 2-bit action that its own action register assigns to the event present and moves its pin low, high, to the opposite level, or leaves it as it is.

A continuous override can hold either pin at a fixed level, whatever the events do. Software writes the override to a shadow copy. The copy becomes active at a point it selects: the zero event, the period event, either of the two, or the next tick. Output A gets high-at-zero and high-at-period with low-at-compare for a normal pulse; inverting all three codes gives the inverted pulse. The counter, dead-band and any polarity stage that follows are outside this block.

Top module: `pwm_action_qual`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), both pins are low, every action field is 00 and no override is active or pending.
- R2: Action codes: 00 keeps the pin, 01 drives it low, 10 drives it high, 11 inverts it. The new level appears at the clock edge of the tick that carries the event.
- R3: Action register layout, written at wr_addr 0 (output A) or 1 (output B): zero-event code in bits 1:0, period-event code in bits 3:2, compare-A code in bits 5:4, compare-B code in bits 9:8. Bits 7:6 of this register have no effect.
- R4: An event strobe during a cycle with tick low changes neither pin.
- R5: When several events arrive on the same tick, only the code of the highest-ranked one is used (compare-B, then compare-A, then period, then zero), even if that code is 00.
- R6: Override register, wr_addr 2: bits 1:0 for output A, bits 3:2 for output B; 01 holds the pin low, 10 holds it high, 00 and 11 release it. An active override beats every event action on that pin.
- R7: Reload field, bits 7:6 of the override register, takes effect on the write: 00 makes the shadow active on a tick with the zero event, 01 on a tick with the period event, 10 on a tick with either, 11 on the next tick. The newly loaded value already controls the pin on that tick.
- R8: Writing the override shadow changes neither pin before its reload point.
- R9: A write to one output's action register leaves the other output's actions unchanged, and writes to wr_addr 3 have no effect.
- R10: Both pins change only at clock edges where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Prescaled time-base tick enable |
| evt_zero | input | 1 | Counter-at-zero event strobe |
| evt_period | input | 1 | Counter-at-period event strobe |
| evt_cmpa | input | 1 | Compare-A up-count match strobe |
| evt_cmpb | input | 1 | Compare-B up-count match strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 action A, 1 action B, 2 override |
| wr_data | input | 10 | Register write data |
| pwm_a | output | 1 | PWM output A |
| pwm_b | output | 1 | PWM output B |

## Verification
A wrong stored action code shows up on the pin at the first tick that carries its event, and a wrong level, for instance a missed toggle, then persists until an absolute code restores it. A wrong active override hides event activity entirely: the pin sits at the forced level from the load tick onward, so one event of the opposite sense is enough to expose it. The stimulus sequences carry state from row to row, and simultaneous events are chosen so that obeying a lower-ranked event would give a different pin level.

// File: rtl/pwmaq_pkg.sv
// Shared encodings for the PWM action stage.
// Assumes: 2-bit action and override codes, four time-base events.
package pwmaq_pkg;

    typedef enum logic [1:0] {
        ACT_NONE = 2'b00,
        ACT_LOW  = 2'b01,
        ACT_HIGH = 2'b10,
        ACT_TOG  = 2'b11
    } act_e;

    typedef enum logic [1:0] {
        RLD_ZERO   = 2'b00,
        RLD_PRD    = 2'b01,
        RLD_EITHER = 2'b10,
        RLD_NOW    = 2'b11
    } rld_e;

    localparam int CODE_W  = 2;
    localparam int NUM_EVT = 4;
    // Event indices; a higher index outranks a lower one.
    localparam int EVT_ZERO = 0;
    localparam int EVT_PRD  = 1;
    localparam int EVT_CMPA = 2;
    localparam int EVT_CMPB = 3;

    localparam logic [CODE_W-1:0] FRC_LOW  = 2'b01;
    localparam logic [CODE_W-1:0] FRC_HIGH = 2'b10;

    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_FORCE = 2'd2;

endpackage

// File: rtl/pwmaq_force_ctl.sv
// Override controller: holds the shadow override value and reload mode,
// and moves the shadow into the active copy at the selected reload point.
// Assumes: event strobes are only meaningful when tick is high.
// eff_force is the override in force on the current tick (shadow when
// loading now, otherwise the active copy).
module pwmaq_force_ctl
    import pwmaq_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int FRC_W = NUM_CH * CODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             evt_zero,
    input  logic             evt_period,
    input  logic             wr_force,
    input  logic [FRC_W-1:0] wr_force_val,
    input  logic [1:0]       wr_mode,
    output logic [FRC_W-1:0] eff_force,
    output logic [FRC_W-1:0] act_force
);

    logic [FRC_W-1:0] shadow_q;
    rld_e             mode_q;
    logic             load_now;

    // Capture shadow value and reload mode from the write port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            mode_q   <= RLD_ZERO;
        end else if (wr_force) begin
            shadow_q <= wr_force_val;
            mode_q   <= rld_e'(wr_mode);
        end
    end

    // Decide whether this tick is a reload point.
    always_comb begin
        unique case (mode_q)
            RLD_ZERO:   load_now = tick && evt_zero;
            RLD_PRD:    load_now = tick && evt_period;
            RLD_EITHER: load_now = tick && (evt_zero || evt_period);
            default:    load_now = tick;
        endcase
    end

    // Transfer shadow into the active override at a reload point.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_force <= '0;
        end else if (load_now) begin
            act_force <= shadow_q;
        end
    end

    // Override seen by the channels on this tick.
    assign eff_force = load_now ? shadow_q : act_force;

endmodule

// File: rtl/pwmaq_chan.sv
// One output channel: stores one action code per event, picks the
// highest-ranked event present on a tick, and updates the pin register.
// Assumes: wr_fields packs the four codes contiguously, zero event lowest;
// an override code of FRC_LOW/FRC_HIGH wins over any event action.
module pwmaq_chan
    import pwmaq_pkg::*;
#(
    localparam int FLD_W = NUM_EVT * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [NUM_EVT-1:0] evt,
    input  logic              wr_act,
    input  logic [FLD_W-1:0]  wr_fields,
    input  logic [CODE_W-1:0] force_code,
    output logic              pwm
);

    act_e act_code [NUM_EVT];
    act_e sel_code;
    logic hit;
    logic pwm_nxt;

    // Store the per-event action codes.
    always_ff @(posedge clk) begin
        for (int e = 0; e < NUM_EVT; e++) begin
            if (!rst_n) begin
                act_code[e] <= ACT_NONE;
            end else if (wr_act) begin
                act_code[e] <= act_e'(wr_fields[e*CODE_W +: CODE_W]);
            end
        end
    end

    // Fixed-priority pick: later (higher-index) events overwrite earlier.
    always_comb begin
        hit      = 1'b0;
        sel_code = ACT_NONE;
        for (int e = 0; e < NUM_EVT; e++) begin
            if (evt[e]) begin
                hit      = 1'b1;
                sel_code = act_code[e];
            end
        end
    end

    // Next pin level: override first, then the chosen event action.
    always_comb begin
        pwm_nxt = pwm;
        if (force_code == FRC_LOW) begin
            pwm_nxt = 1'b0;
        end else if (force_code == FRC_HIGH) begin
            pwm_nxt = 1'b1;
        end else if (hit) begin
            unique case (sel_code)
                ACT_LOW:  pwm_nxt = 1'b0;
                ACT_HIGH: pwm_nxt = 1'b1;
                ACT_TOG:  pwm_nxt = ~pwm;
                default:  pwm_nxt = pwm;
            endcase
        end
    end

    // Pin register advances only on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwm <= 1'b0;
        end else if (tick) begin
            pwm <= pwm_nxt;
        end
    end

endmodule

// File: rtl/pwm_action_qual.sv
// Top of the PWM action stage: decodes register writes, runs the override
// controller and one channel per output.
// Assumes: write data fields as in the brief; writes and ticks may coincide,
// in which case the tick uses the register contents before the write.
module pwm_action_qual
    import pwmaq_pkg::*;
#(
    localparam int NUM_CH = 2,
    localparam int WR_W   = 10,
    localparam int FRC_W  = NUM_CH * CODE_W,
    localparam int FLD_W  = NUM_EVT * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              evt_zero,
    input  logic              evt_period,
    input  logic              evt_cmpa,
    input  logic              evt_cmpb,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WR_W-1:0]   wr_data,
    output logic              pwm_a,
    output logic              pwm_b
);

    logic [NUM_EVT-1:0] evt_vec;
    logic [FRC_W-1:0]   eff_force;
    logic [FRC_W-1:0]   act_force;
    logic [FLD_W-1:0]   act_fields;
    logic [NUM_CH-1:0]  pwm_vec;

    // Gather event strobes in rank order, lowest first.
    assign evt_vec = {evt_cmpb, evt_cmpa, evt_period, evt_zero};

    // Pack action fields contiguously; bits 7:6 of the word are skipped.
    assign act_fields = {wr_data[9:8], wr_data[5:0]};

    pwmaq_force_ctl #(
        .NUM_CH (NUM_CH)
    ) u_force (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .evt_zero     (evt_zero),
        .evt_period   (evt_period),
        .wr_force     (wr_en && (wr_addr == ADDR_FORCE)),
        .wr_force_val (wr_data[FRC_W-1:0]),
        .wr_mode      (wr_data[7:6]),
        .eff_force    (eff_force),
        .act_force    (act_force)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        pwmaq_chan u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick),
            .evt        (evt_vec),
            .wr_act     (wr_en && (wr_addr == ADDR_W'(c))),
            .wr_fields  (act_fields),
            .force_code (eff_force[c*CODE_W +: CODE_W]),
            .pwm        (pwm_vec[c])
        );
    end

    assign pwm_a = pwm_vec[0];
    assign pwm_b = pwm_vec[1];

endmodule

// File: rtl/pwm_action_qual_checker.sv
// Property checker for pwm_action_qual, attached with bind.
// Assumes the override encoding 01 = low, 10 = high per output.
module pwm_action_qual_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       pwm_a,
    input logic       pwm_b,
    input logic [3:0] eff_force,
    input logic [3:0] act_force
);

    // R1: a reset edge leaves both pins low.
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!pwm_a && !pwm_b));

    // R10: no tick, no pin change.
    a_r10_hold_a: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pwm_a));
    a_r10_hold_b: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(pwm_b));

    // R6: an override in force on a tick sets the pin level.
    a_r6_force_low_a: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eff_force[1:0] == 2'b01) |=> !pwm_a);
    a_r6_force_high_a: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eff_force[1:0] == 2'b10) |=> pwm_a);
    a_r6_force_low_b: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eff_force[3:2] == 2'b01) |=> !pwm_b);
    a_r6_force_high_b: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && eff_force[3:2] == 2'b10) |=> pwm_b);

    // R7: the active override only reloads on a tick.
    a_r7_reload_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(act_force));

endmodule

bind pwm_action_qual pwm_action_qual_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .pwm_a     (pwm_a),
    .pwm_b     (pwm_b),
    .eff_force (eff_force),
    .act_force (act_force)
);

// File: tb/pwm_action_qual_bench.sv
module pwm_action_qual_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       evt_zero = 1'b0, evt_period = 1'b0, evt_cmpa = 1'b0, evt_cmpb = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [9:0] wr_data = 10'd0;
    logic       pwm_a, pwm_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_action_qual u_pwm_action_qual (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .evt_zero(evt_zero), .evt_period(evt_period),
        .evt_cmpa(evt_cmpa), .evt_cmpb(evt_cmpb),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_a(pwm_a), .pwm_b(pwm_b)
    );

    // Row: {tick, evt[3:0] = {cmpb, cmpa, prd, zero}, exp_a, exp_b}.
    // Action A = 0x01A (zero high, prd high, cmpA low, cmpB none).
    // Action B = 0x231 (zero low, prd none, cmpA toggle, cmpB high).
    localparam bit [6:0] VEC [0:11] = '{
        7'b1_0001_1_0, 7'b0_0100_1_0, 7'b1_0100_0_1, 7'b1_0100_0_0,
        7'b1_1000_0_1, 7'b1_1101_0_1, 7'b1_0010_1_1, 7'b1_0110_0_0,
        7'b1_0011_1_0, 7'b1_0000_1_0, 7'b1_0100_0_1, 7'b1_0011_1_1
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic chk2(input string req, input logic ea, input logic eb);
        check({req, " pwm_a"}, pwm_a, ea);
        check({req, " pwm_b"}, pwm_b, eb);
    endtask

    // One cycle with the given tick and events; returns at the next negedge.
    task automatic cyc(input logic t, input logic [3:0] ev);
        @(negedge clk);
        tick = t;
        {evt_cmpb, evt_cmpa, evt_period, evt_zero} = ev;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        {evt_cmpb, evt_cmpa, evt_period, evt_zero} = 4'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [9:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk2("R1 reset", 1'b0, 1'b0);
        rst_n = 1'b1;
        // R1: with all actions 00 after reset, events do nothing.
        cyc(1'b1, 4'b1111);
        chk2("R1 actions none", 1'b0, 1'b0);

        wr(2'd0, 10'h01A);
        wr(2'd1, 10'h231);
        // R2 R4 R5: table walk, state carried between rows.
        for (int i = 0; i < 12; i++) begin
            cyc(VEC[i][6], VEC[i][5:2]);
            chk2($sformatf("R2/R4/R5 row %0d", i), VEC[i][1], VEC[i][0]);
        end
        // Now A=1, B=1.

        // R8: A low pending until zero (mode 00); period tick keeps A high.
        wr(2'd2, 10'h001);
        cyc(1'b1, 4'b0010);
        chk2("R8 shadow pending", 1'b1, 1'b1);
        cyc(1'b1, 4'b0001);
        chk2("R7 load at zero", 1'b0, 1'b0);
        cyc(1'b1, 4'b0010);
        chk2("R6 force beats period high", 1'b0, 1'b0);

        // R7 mode 01: A release, B high, load at period only.
        wr(2'd2, 10'h048);
        cyc(1'b1, 4'b0001);
        chk2("R7 period mode ignores zero", 1'b0, 1'b0);
        cyc(1'b1, 4'b0010);
        chk2("R7 load at period", 1'b1, 1'b1);

        // R7 mode 10 with code 11 on A (release) and 00 on B.
        wr(2'd2, 10'h083);
        cyc(1'b1, 4'b0001);
        chk2("R6 code 11 releases, R7 either", 1'b1, 1'b0);

        // R7 immediate: A low, B high from next tick.
        wr(2'd2, 10'h0C9);
        cyc(1'b0, 4'b0000);
        chk2("R10 no tick no change", 1'b1, 1'b0);
        cyc(1'b1, 4'b0000);
        chk2("R7 immediate load", 1'b0, 1'b1);
        wr(2'd2, 10'h0C0);
        cyc(1'b1, 4'b0000);
        chk2("R6 release holds level", 1'b0, 1'b1);

        // R3: bits 7:6 of action A ignored -> all A codes 00.
        wr(2'd0, 10'h0C0);
        cyc(1'b1, 4'b0001);
        check("R3 ignored bits pwm_a", pwm_a, 1'b0);
        check("R9 B actions kept pwm_b", pwm_b, 1'b0);
        // R9: address 3 write has no effect.
        wr(2'd3, 10'h3FF);
        cyc(1'b1, 4'b1111);
        chk2("R9 addr3 ignored", 1'b0, 1'b1);

        // R1: reset mid-run clears pin and actions.
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); @(negedge clk); rst_n = 1'b1;
        chk2("R1 mid-run reset", 1'b0, 1'b0);
        cyc(1'b1, 4'b1000);
        chk2("R1 actions cleared", 1'b0, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule